// File: doc/BRIEF.md
# Chip-Select Bus Cycle Terminator

This block ends external bus cycles for one programmable chip-select channel. When the address strobe asserts while the address-match input is high, a small state machine counts bus clocks. It ends the cycle by one of three routes: an acknowledge it generates itself after a programmed number of wait states, an acknowledge from the external device, or a two-clock fast termination. It also drives the chip-select output and a data-strobe enable, and it pulses a cycle-done flag for one clock when the cycle ends.

The 4-bit wait field of the option register selects the termination:

| Value | Meaning |
|---|---|
| 0 to 13 | That many wait states before the internal acknowledge |
| 14 | Fast termination |
| 15 | External acknowledge only |

The external acknowledge lines are sampled in every cycle, whatever the field holds. An external device can therefore always end a cycle. If it holds its acknowledge asserted, every non-fast cycle becomes a zero-wait, three-clock access.

A strobe-select bit chooses what the chip-select follows: the address strobe, or the data strobe. On a fast-termination write the data strobe stays negated. A chip-select that follows the data strobe therefore never asserts on such a write.

All control inputs and outputs are active high. Clock 1 of a cycle is the clock that follows the rising edge on which the address strobe and the address match were first both seen.

Top module: `cs_term`

## Requirements
- R1: After reset, int_ack is 2'b00 and cs_out, ds_en and cycle_done are 0.
- R2: With wait field 0 and no external acknowledge, cycle_done is high in clock 3 of the cycle.
- R3: With a wait field value w from 0 to 13 and no external acknowledge, cycle_done is high in clock w+3 and int_ack is 2'b11 from that clock on.
- R4: With wait field 15, int_ack stays 2'b00 and the cycle ends only on an external acknowledge. Without one it never ends.
- R5: An external acknowledge (either ext_ack bit high) that is sampled on the rising edge that ends clock k, with k at least 2, ends the cycle in clock k+1. This applies to any field other than 14. When the external acknowledge ends the cycle before the internal count, int_ack stays 2'b00.
- R6: With wait field 14 (fast termination), cycle_done is high in clock 2 and int_ack is 2'b11, even when the external acknowledge is held.
- R7: ds_en is high during a cycle, except on a fast-termination write (rd_wr=0), where it stays 0 for the whole cycle.
- R8: With opt_strobe_as=1, cs_out is high during the cycle. With opt_strobe_as=0, cs_out follows ds_en, so it never asserts on a fast-termination write.
- R9: cycle_done is a single-clock pulse. int_ack holds its value until the address strobe negates. In the clock after the negation, int_ack, cs_out and ds_en are all 0.
- R10: When the internal and external acknowledges fall on the same edge, the cycle ends once, with one cycle_done pulse, and int_ack is 2'b11.
- R11: An address strobe without sel_hit starts no cycle: cs_out, ds_en and cycle_done stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strobe | input | 1 | Address strobe, high while the cycle runs |
| rd_wr | input | 1 | 1 = read, 0 = write |
| sel_hit | input | 1 | Address falls in this channel's range |
| ext_ack | input | 2 | External acknowledge lines |
| opt_wait | input | 4 | Wait/termination field (0-13 wait states, 14 fast, 15 external only) |
| opt_strobe_as | input | 1 | 1 = chip-select follows the address strobe, 0 = follows the data strobe |
| int_ack | output | 2 | Internal acknowledge, both lines together |
| cs_out | output | 1 | Chip-select |
| ds_en | output | 1 | Data-strobe enable |
| cycle_done | output | 1 | One-clock pulse at the end of a cycle |

## Verification
The assertions check these properties on every cycle:
- cycle_done is a single-clock pulse.
- The acknowledge clears after the address strobe negates.
- ds_en stays low on fast writes.
- The fast cycle ends after its second clock.
- An external acknowledge ends the cycle one clock after it is sampled.
- No internal acknowledge appears in external-only mode.
- An unmatched strobe leaves the outputs low.

Only the bench's sweep can show the exact length of each cycle. It runs every field value against both directions, both strobe selections and three external-acknowledge patterns. The sweep also shows which acknowledge wins a race, that a tie produces only one pulse, and the chip-select gating that follows from the strobe choice.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } cyc_st_e;
endpackage

// File: rtl/cs_term_wait.sv
module cs_term_wait #(
    parameter int FIELD_W = 4,
    parameter int CNT_W   = 5
) (
    input  logic [FIELD_W-1:0] fld,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               ext_any,
    output logic               int_hit,
    output logic               ext_hit
);
    localparam logic [FIELD_W-1:0] EXT_CODE  = {FIELD_W{1'b1}};
    localparam logic [FIELD_W-1:0] FAST_CODE = EXT_CODE - 1'b1;

    logic [CNT_W-1:0] target;

    always_comb begin
        target  = {{(CNT_W-FIELD_W){1'b0}}, fld} + {{(CNT_W-2){1'b0}}, 2'd2};
        int_hit = 1'b0;
        if (fld == FAST_CODE) begin
            int_hit = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});
        end else if (fld != EXT_CODE) begin
            int_hit = (cnt == target);
        end
        ext_hit = ext_any && (cnt >= {{(CNT_W-2){1'b0}}, 2'd2});
    end
endmodule

// File: rtl/cs_term_strobe.sv
module cs_term_strobe (
    input  logic active_nxt,
    input  logic rd,
    input  logic fast,
    input  logic sas,
    output logic ds_nxt,
    output logic cs_nxt
);
    always_comb begin
        ds_nxt = active_nxt && (rd || !fast);
        cs_nxt = active_nxt && (sas || ds_nxt);
    end
endmodule

// File: rtl/cs_term.sv
module cs_term
    import cs_term_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int ACK_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_strobe,
    input  logic               rd_wr,
    input  logic               sel_hit,
    input  logic [ACK_W-1:0]   ext_ack,
    input  logic [FIELD_W-1:0] opt_wait,
    input  logic               opt_strobe_as,
    output logic [ACK_W-1:0]   int_ack,
    output logic               cs_out,
    output logic               ds_en,
    output logic               cycle_done
);
    localparam int CNT_W = FIELD_W + 1;
    localparam logic [FIELD_W-1:0] EXT_CODE  = {FIELD_W{1'b1}};
    localparam logic [FIELD_W-1:0] FAST_CODE = EXT_CODE - 1'b1;

    typedef struct packed {
        cyc_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [FIELD_W-1:0] fld;
        logic               rd;
        logic               sas;
        logic [ACK_W-1:0]   ack;
        logic               done;
        logic               ds;
        logic               cs;
    } term_s;

    term_s state_d, state_q;

    logic               start, active_nxt, int_hit, ext_hit, ds_nxt, cs_nxt;
    logic               cyc_rd, cyc_sas;
    logic [FIELD_W-1:0] cyc_fld;

    assign start      = (state_q.st == ST_IDLE) && addr_strobe && sel_hit;
    assign active_nxt = start || ((state_q.st != ST_IDLE) && addr_strobe);
    assign cyc_rd     = start ? rd_wr         : state_q.rd;
    assign cyc_sas    = start ? opt_strobe_as : state_q.sas;
    assign cyc_fld    = start ? opt_wait      : state_q.fld;

    cs_term_wait #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_wait (
        .fld     (state_q.fld),
        .cnt     (state_q.cnt),
        .ext_any (|ext_ack),
        .int_hit (int_hit),
        .ext_hit (ext_hit)
    );

    cs_term_strobe u_strobe (
        .active_nxt (active_nxt),
        .rd         (cyc_rd),
        .fast       (cyc_fld == FAST_CODE),
        .sas        (cyc_sas),
        .ds_nxt     (ds_nxt),
        .cs_nxt     (cs_nxt)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (start) begin
                    state_d.st  = ST_RUN;
                    state_d.cnt = {{(CNT_W-1){1'b0}}, 1'b1};
                    state_d.fld = opt_wait;
                    state_d.rd  = rd_wr;
                    state_d.sas = opt_strobe_as;
                end
            end
            ST_RUN: begin
                if (!addr_strobe) begin
                    state_d.st = ST_IDLE;
                end else if (int_hit || ext_hit) begin
                    state_d.st   = ST_HOLD;
                    state_d.done = 1'b1;
                    if (int_hit) state_d.ack = {ACK_W{1'b1}};
                end else if (state_q.cnt != {CNT_W{1'b1}}) begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!addr_strobe) state_d.st = ST_IDLE;
            end
            default: state_d.st = ST_IDLE;
        endcase
        if (state_d.st == ST_IDLE) state_d.ack = '0;
        state_d.ds = ds_nxt;
        state_d.cs = cs_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: ST_IDLE, default: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign int_ack    = state_q.ack;
    assign cs_out     = state_q.cs;
    assign ds_en      = state_q.ds;
    assign cycle_done = state_q.done;

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);
    a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_HOLD && !addr_strobe) |=> (int_ack == '0 && !cs_out && !ds_en));
    a_r7_fast_write_no_ds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st != ST_IDLE && state_q.fld == FAST_CODE && !state_q.rd) |-> !ds_en);
    a_r6_fast_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_RUN && state_q.fld == FAST_CODE && state_q.cnt == 1 && addr_strobe)
        |=> (cycle_done && int_ack == {ACK_W{1'b1}}));
    a_r5_ext_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_RUN && addr_strobe && (|ext_ack) && state_q.cnt >= 2) |=> cycle_done);
    a_r4_ext_only_no_int: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st != ST_IDLE && state_q.fld == EXT_CODE) |-> int_ack == '0);
    a_r11_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_IDLE && !sel_hit) |=> (!cs_out && !ds_en && !cycle_done));
endmodule

// File: tb/cs_term_tb.sv
module cs_term_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_strobe = 1'b0, rd_wr = 1'b0, sel_hit = 1'b0, opt_strobe_as = 1'b0;
    logic [1:0] ext_ack = 2'b00;
    logic [3:0] opt_wait = 4'd0;
    logic [1:0] int_ack;
    logic       cs_out, ds_en, cycle_done;

    int checks = 0;
    int failures = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    cs_term u_dut (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .rd_wr(rd_wr),
        .sel_hit(sel_hit), .ext_ack(ext_ack), .opt_wait(opt_wait),
        .opt_strobe_as(opt_strobe_as), .int_ack(int_ack), .cs_out(cs_out),
        .ds_en(ds_en), .cycle_done(cycle_done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // emode: 0 no external ack, 1 held from start, 2 asserted after clock 5
    task automatic run_cycle(input int fld, input bit rd, input bit sas, input int emode);
        int done_k = 0, ndone = 0, ack_at = 0, exp_len = 0, exp_ack;
        bit ds_any = 0, cs_any = 0, exp_ds, exp_cs;
        string tag;
        @(negedge clk);
        opt_wait = 4'(fld); rd_wr = rd; opt_strobe_as = sas;
        sel_hit = 1'b1; addr_strobe = 1'b1;
        ext_ack = (emode == 1) ? 2'b11 : 2'b00;
        for (int k = 1; k <= 40 && done_k == 0; k++) begin
            @(posedge clk); #1;
            if (ds_en) ds_any = 1;
            if (cs_out) cs_any = 1;
            if (cycle_done) begin done_k = k; ack_at = int_ack; ndone++; end
            if (emode == 2 && k == 5) ext_ack = 2'b11;
        end
        // expected termination clock, computed from the requirements
        if (fld == 14) exp_len = 2;
        else begin
            if (fld <= 13) exp_len = fld + 3;
            if (emode == 1 && (exp_len == 0 || exp_len > 3)) exp_len = 3;
            if (emode == 2 && (exp_len == 0 || exp_len > 6)) exp_len = 6;
        end
        exp_ack = (fld == 14 || (fld <= 13 && fld + 3 == exp_len)) ? 3 : 0;
        exp_ds  = rd || (fld != 14);
        exp_cs  = sas ? 1'b1 : exp_ds;
        if (fld == 14) tag = "R6";
        else if (emode == 0) tag = (fld == 15) ? "R4" : (fld == 0 ? "R2" : "R3");
        else if (fld <= 13 && fld + 3 == exp_len && exp_len == ((emode == 1) ? 3 : 6)) tag = "R10";
        else tag = "R5";
        chk(tag, "done clock", done_k, exp_len);
        chk(tag, "int_ack at done", ack_at, exp_ack);
        chk(tag, "done pulses", ndone, (exp_len == 0) ? 0 : 1);
        chk("R7", "ds_en seen", ds_any, exp_ds);
        chk("R8", "cs_out seen", cs_any, exp_cs);
        @(posedge clk); #1;
        chk("R9", "done after pulse", cycle_done, 0);
        chk("R9", "int_ack held", int_ack, ack_at);
        addr_strobe = 1'b0; ext_ack = 2'b00;
        @(posedge clk); #1;
        chk("R9", "released ack/cs/ds", {int_ack, cs_out, ds_en}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset outputs", {int_ack, cs_out, ds_en, cycle_done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "outputs after reset release", {int_ack, cs_out, ds_en, cycle_done}, 0);

        // strobe without a match
        @(negedge clk); sel_hit = 1'b0; addr_strobe = 1'b1; opt_wait = 4'd0; opt_strobe_as = 1'b1; rd_wr = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            chk("R11", "unmatched strobe outputs", {cs_out, ds_en, cycle_done}, 0);
        end
        @(negedge clk); addr_strobe = 1'b0;
        @(posedge clk); #1;

        for (int f = 0; f < 16; f++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 2; s++)
                    for (int e = 0; e < 3; e++)
                        run_cycle(f, r[0], s[0], e);

        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule